// File: doc/BRIEF.md
# Dual-Edge Pin Interrupt Controller

This block watches a bank of general-purpose input pins and turns their transitions into interrupt requests. Each pin is synchronized to the local clock. Each pin can be run in one of two ways. In single-edge mode, a per-pin polarity bit picks which transition counts. In either-edge mode, both transitions count and the polarity bit no longer matters for detection.

Detected events are recorded in three sticky status vectors: a wake-event vector, a system-management vector, and a miscellaneous vector that records only either-edge activity. Every status bit is cleared by writing 1 to it. Two level interrupt outputs combine the status bits with per-pin enable bits. A pin can raise an interrupt only while it is in either-edge mode. A small register bus gives access to the configuration bits, the pin data and the status vectors. Reads are combinational. Writes take effect on the clock edge on which the write strobe is sampled.

Register map (4-bit address, 8-bit data, bit i belongs to pin i, unused bits read 0):

| Address | Access | Contents |
|---|---|---|
| 0 | read/write | either-edge mode select |
| 1 | read/write | polarity |
| 2 | read/write | direction (stored only) |
| 3 | read/write | wake interrupt enable |
| 4 | read/write | system-management interrupt enable |
| 5 | read-only | data: synchronized pin level XOR polarity |
| 6 | write-1-to-clear | wake status |
| 7 | write-1-to-clear | system-management status |
| 8 | write-1-to-clear | miscellaneous (either-edge) status |

Top module: `dual_edge_irq_ctl`

## Requirements
- R1: A pin change is seen on the data register (address 5) two clocks after the pin changes. It sets status one clock after that: three clocks in all.
- R2: In single-edge mode with polarity 0, a rising edge sets the pin's wake and management status bits (addresses 6 and 7). A falling edge sets neither.
- R3: In single-edge mode with polarity 1, a falling edge sets the wake and management status bits. A rising edge sets neither.
- R4: In either-edge mode (address 0 bit set), both edges set the wake, management and miscellaneous status bits (addresses 6, 7, 8), whatever the polarity bit holds.
- R5: The direction bits (address 2) are readable and writable. They have no effect on event detection.
- R6: Data bit i (address 5) reads as the synchronized pin level XOR polarity bit i, in both modes.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: If an event and a write-1-to-clear hit the same status bit in the same cycle, the bit stays set.
- R9: Miscellaneous status bits (address 8) are never set while the pin is in single-edge mode.
- R10: Status bits record events even when the matching interrupt enable is 0. The interrupt output then stays low.
- R11: wake_irq is high exactly when some pin has its wake status, wake enable and mode bits all set; mgmt_irq follows the same rule with the management bits. Each output stays high until the status is cleared.
- R12: After reset, all registers read 0 and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous pin inputs |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| wake_irq | output | 1 | Wake-event interrupt level |
| mgmt_irq | output | 1 | System-management interrupt level |

## Verification
Rising-only and falling-only pin patterns are applied in single-edge mode with each polarity value. This shows whether the edge selector follows the polarity bit or accepts every edge. The same patterns are then repeated in either-edge mode, with the direction bits set and the polarity mixed. This separates "both edges count" from "polarity still steers detection", and a mode-dependent miscellaneous bit from one that is always set.

A single-pin toggle is sampled on consecutive cycles to pin down the synchronizer depth. A clear write is timed to land on the same edge as a new event, which distinguishes set-wins priority from clear-wins. Enabled and disabled interrupt combinations show whether an interrupt output is gated by both its enable and the mode bit.

// File: rtl/deg_pkg.sv
package deg_pkg;

  parameter int unsigned REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    REG_MODE = 4'd0,
    REG_POL  = 4'd1,
    REG_DIR  = 4'd2,
    REG_WKEN = 4'd3,
    REG_MGEN = 4'd4,
    REG_DATA = 4'd5,
    REG_WSTS = 4'd6,
    REG_MSTS = 4'd7,
    REG_MISC = 4'd8
  } reg_sel_e;

  // Number of sticky status vectors kept per pin
  localparam int unsigned NUM_BANKS = 3;
  localparam int unsigned BANK_WAKE = 0;
  localparam int unsigned BANK_MGMT = 1;
  localparam int unsigned BANK_MISC = 2;

  // Event that drives the wake and management status bits of one pin
  function automatic logic sel_edge(logic ee, logic inv, logic rise, logic fall);
    if (ee) return rise | fall;
    return inv ? fall : rise;
  endfunction

  // Event that drives the miscellaneous status bit of one pin
  function automatic logic misc_edge(logic ee, logic rise, logic fall);
    return ee & (rise | fall);
  endfunction

  // Next value of a sticky bit: a new event wins over a clear
  function automatic logic sticky_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/deg_pin_sync.sv
module deg_pin_sync #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= pin_i[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end

    assign level_o[i] = sync_q;
    assign rise_o[i]  = sync_q & ~prev_q;
    assign fall_o[i]  = ~sync_q & prev_q;
  end

endmodule

// File: rtl/deg_event_sel.sv
module deg_event_sel
  import deg_pkg::*;
#(
  parameter int unsigned N = 6
) (
  input  logic [N-1:0] mode_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] fall_i,
  output logic [N-1:0] evt_std_o,
  output logic [N-1:0] evt_misc_o
);

  for (genvar i = 0; i < N; i++) begin : g_sel
    assign evt_std_o[i]  = sel_edge(mode_i[i], pol_i[i], rise_i[i], fall_i[i]);
    assign evt_misc_o[i] = misc_edge(mode_i[i], rise_i[i], fall_i[i]);
  end

endmodule

// File: rtl/deg_sticky_bank.sv
module deg_sticky_bank
  import deg_pkg::*;
#(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o
);

  logic [N-1:0] sts_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q[i] <= 1'b0;
      else        sts_q[i] <= sticky_next(sts_q[i], set_i[i], clr_i[i]);
    end
  end

  assign sts_o = sts_q;

endmodule

// File: rtl/deg_regfile.sv
module deg_regfile
  import deg_pkg::*;
#(
  parameter int unsigned N      = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N-1:0]      level_i,
  input  logic [N-1:0]      wake_sts_i,
  input  logic [N-1:0]      mgmt_sts_i,
  input  logic [N-1:0]      misc_sts_i,
  output logic [N-1:0]      mode_o,
  output logic [N-1:0]      pol_o,
  output logic [N-1:0]      dir_o,
  output logic [N-1:0]      wake_en_o,
  output logic [N-1:0]      mgmt_en_o,
  output logic [N-1:0]      clr_wake_o,
  output logic [N-1:0]      clr_mgmt_o,
  output logic [N-1:0]      clr_misc_o
);

  localparam int unsigned PAD_W = DATA_W - N;

  logic [N-1:0] wbits;
  logic [N-1:0] mode_q, pol_q, dir_q, wken_q, mgen_q;
  logic [N-1:0] rd_bits;

  assign wbits = bus_wdata[N-1:0];

  if (PAD_W > 0) begin : g_pad
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:N];
    assign bus_rdata = {{PAD_W{1'b0}}, rd_bits};
  end else begin : g_nopad
    assign bus_rdata = rd_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      pol_q  <= '0;
      dir_q  <= '0;
      wken_q <= '0;
      mgen_q <= '0;
    end else if (bus_we) begin
      unique case (bus_addr)
        REG_MODE: mode_q <= wbits;
        REG_POL:  pol_q  <= wbits;
        REG_DIR:  dir_q  <= wbits;
        REG_WKEN: wken_q <= wbits;
        REG_MGEN: mgen_q <= wbits;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (bus_addr)
      REG_MODE: rd_bits = mode_q;
      REG_POL:  rd_bits = pol_q;
      REG_DIR:  rd_bits = dir_q;
      REG_WKEN: rd_bits = wken_q;
      REG_MGEN: rd_bits = mgen_q;
      REG_DATA: rd_bits = level_i ^ pol_q;
      REG_WSTS: rd_bits = wake_sts_i;
      REG_MSTS: rd_bits = mgmt_sts_i;
      REG_MISC: rd_bits = misc_sts_i;
      default:  rd_bits = '0;
    endcase
  end

  assign clr_wake_o = (bus_we && bus_addr == REG_WSTS) ? wbits : '0;
  assign clr_mgmt_o = (bus_we && bus_addr == REG_MSTS) ? wbits : '0;
  assign clr_misc_o = (bus_we && bus_addr == REG_MISC) ? wbits : '0;

  assign mode_o    = mode_q;
  assign pol_o     = pol_q;
  assign dir_o     = dir_q;
  assign wake_en_o = wken_q;
  assign mgmt_en_o = mgen_q;

endmodule

// File: rtl/dual_edge_irq_ctl.sv
module dual_edge_irq_ctl
  import deg_pkg::*;
#(
  parameter int unsigned NUM_PINS = 6,
  parameter int unsigned DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [REG_AW-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                wake_irq,
  output logic                mgmt_irq
);

  logic [NUM_PINS-1:0] level, rise, fall;
  logic [NUM_PINS-1:0] evt_std, evt_misc;
  logic [NUM_PINS-1:0] mode, pol, dir, wake_en, mgmt_en;
  logic [NUM_PINS-1:0] clr_wake, clr_mgmt, clr_misc;
  logic [NUM_PINS-1:0] wake_sts, mgmt_sts, misc_sts;
  logic [NUM_PINS-1:0] bank_set [NUM_BANKS];
  logic [NUM_PINS-1:0] bank_clr [NUM_BANKS];
  logic [NUM_PINS-1:0] bank_sts [NUM_BANKS];
  logic                unused_dir;

  deg_pin_sync #(.N(NUM_PINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (pin_i),
    .level_o (level),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  deg_event_sel #(.N(NUM_PINS)) u_sel (
    .mode_i     (mode),
    .pol_i      (pol),
    .rise_i     (rise),
    .fall_i     (fall),
    .evt_std_o  (evt_std),
    .evt_misc_o (evt_misc)
  );

  assign bank_set[BANK_WAKE] = evt_std;
  assign bank_set[BANK_MGMT] = evt_std;
  assign bank_set[BANK_MISC] = evt_misc;
  assign bank_clr[BANK_WAKE] = clr_wake;
  assign bank_clr[BANK_MGMT] = clr_mgmt;
  assign bank_clr[BANK_MISC] = clr_misc;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    deg_sticky_bank #(.N(NUM_PINS)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (bank_set[b]),
      .clr_i (bank_clr[b]),
      .sts_o (bank_sts[b])
    );
  end

  assign wake_sts = bank_sts[BANK_WAKE];
  assign mgmt_sts = bank_sts[BANK_MGMT];
  assign misc_sts = bank_sts[BANK_MISC];

  deg_regfile #(.N(NUM_PINS), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .level_i    (level),
    .wake_sts_i (wake_sts),
    .mgmt_sts_i (mgmt_sts),
    .misc_sts_i (misc_sts),
    .mode_o     (mode),
    .pol_o      (pol),
    .dir_o      (dir),
    .wake_en_o  (wake_en),
    .mgmt_en_o  (mgmt_en),
    .clr_wake_o (clr_wake),
    .clr_mgmt_o (clr_mgmt),
    .clr_misc_o (clr_misc)
  );

  // Direction is kept for software only; detection never looks at it
  assign unused_dir = ^dir;

  assign wake_irq = |(wake_sts & wake_en & mode);
  assign mgmt_irq = |(mgmt_sts & mgmt_en & mode);

endmodule

// File: rtl/deg_chk.sv
module deg_chk #(
  parameter int unsigned N = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] mode,
  input logic [N-1:0] rise,
  input logic [N-1:0] fall,
  input logic [N-1:0] wake_sts,
  input logic [N-1:0] misc_sts,
  input logic [N-1:0] clr_wake,
  input logic [N-1:0] wake_en,
  input logic [N-1:0] mgmt_en,
  input logic         wake_irq,
  input logic         mgmt_irq
);

  // R4
  ee_edge_sets_misc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(mode) & ($past(rise) | $past(fall)) & ~misc_sts) == '0));

  // R9
  misc_only_in_ee_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((misc_sts & ~$past(misc_sts) & ~$past(mode)) == '0));

  // R7
  clear_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr_wake) & ~($past(rise) | $past(fall)) & wake_sts) == '0));

  // R8
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(wake_sts) & ~$past(clr_wake) & ~wake_sts) == '0));

  // R2
  no_set_without_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((wake_sts & ~$past(wake_sts) & ~($past(rise) | $past(fall))) == '0));

  // R11
  wake_irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> ((wake_sts & wake_en & mode) != '0));

  // R10
  mgmt_irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_en == '0) |-> !mgmt_irq);

endmodule

bind dual_edge_irq_ctl deg_chk #(.N(NUM_PINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode),
  .rise     (rise),
  .fall     (fall),
  .wake_sts (wake_sts),
  .misc_sts (misc_sts),
  .clr_wake (clr_wake),
  .wake_en  (wake_en),
  .mgmt_en  (mgmt_en),
  .wake_irq (wake_irq),
  .mgmt_irq (mgmt_irq)
);

// File: tb/tb_dual_edge_irq_ctl.sv
`timescale 1ns/1ps
module tb_dual_edge_irq_ctl;

  localparam int NP = 6;
  localparam int DW = 8;
  localparam logic [3:0] A_MODE = 4'd0, A_POL = 4'd1, A_DIR = 4'd2, A_WKEN = 4'd3,
                         A_MGEN = 4'd4, A_DATA = 4'd5, A_WSTS = 4'd6, A_MSTS = 4'd7,
                         A_MISC = 4'd8, A_IRQ = 4'd15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic [3:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          wake_irq, mgmt_irq;

  always #2.5 clk = ~clk;

  dual_edge_irq_ctl #(.NUM_PINS(NP), .DATA_W(DW)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pins),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wake_irq  (wake_irq),
    .mgmt_irq  (mgmt_irq)
  );

  typedef struct {
    logic [3:0]    addr;
    logic [DW-1:0] exp;
    string         tag;
  } item_t;

  item_t q[$];
  logic  mon_req = 1'b0;
  int    n_chk = 0;
  int    n_err = 0;
  bit    done = 1'b0;

  // Monitor: pops the expected item and compares it with what the design shows
  initial forever begin
    @(negedge clk);
    #1;
    if (mon_req && q.size() > 0) begin
      item_t it;
      logic [DW-1:0] act;
      it  = q.pop_front();
      act = (it.addr == A_IRQ) ? {{(DW-2){1'b0}}, wake_irq, mgmt_irq} : bus_rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr, act, it.exp);
      end
    end
  end

  // All tasks start and end at a falling clock edge
  task automatic chk(input logic [3:0] a, input logic [DW-1:0] e, input string tag);
    item_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    q.push_back(it);
    bus_addr = a;
    mon_req  = 1'b1;
    @(negedge clk);
    mon_req  = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic set_pins(input logic [NP-1:0] v);
    pins = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic clr_all();
    wr(A_WSTS, 8'h3F);
    wr(A_MSTS, 8'h3F);
    wr(A_MISC, 8'h3F);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk(A_MODE, 8'h00, "R12 mode");
    chk(A_POL,  8'h00, "R12 pol");
    chk(A_WKEN, 8'h00, "R12 wken");
    chk(A_WSTS, 8'h00, "R12 wsts");
    chk(A_MSTS, 8'h00, "R12 msts");
    chk(A_MISC, 8'h00, "R12 misc");
    chk(A_IRQ,  8'h00, "R12 irq");

    // R2 rising edges, polarity 0
    set_pins(6'b000101);
    chk(A_WSTS, 8'h05, "R2 rise wsts");
    chk(A_MSTS, 8'h05, "R2 rise msts");
    chk(A_MISC, 8'h00, "R9 misc single-edge");
    chk(A_DATA, 8'h05, "R6 data pol0");
    // R7 write-1-to-clear
    wr(A_WSTS, 8'h01);
    chk(A_WSTS, 8'h04, "R7 clear one");
    wr(A_WSTS, 8'h00);
    chk(A_WSTS, 8'h04, "R7 write zero");
    clr_all();
    set_pins(6'b000000);
    chk(A_WSTS, 8'h00, "R2 fall ignored");
    chk(A_MSTS, 8'h00, "R2 fall ignored msts");

    // R3 polarity 1 on pins 0,1
    wr(A_POL, 8'h03);
    set_pins(6'b000011);
    chk(A_WSTS, 8'h00, "R3 rise ignored");
    chk(A_DATA, 8'h00, "R6 data inverted");
    set_pins(6'b000000);
    chk(A_WSTS, 8'h03, "R3 fall wsts");
    chk(A_MSTS, 8'h03, "R3 fall msts");
    chk(A_DATA, 8'h03, "R6 data inverted low");
    wr(A_WKEN, 8'h3F);
    wr(A_MGEN, 8'h3F);
    chk(A_IRQ, 8'h00, "R11 no irq in single-edge");
    clr_all();
    wr(A_WKEN, 8'h00);
    wr(A_MGEN, 8'h00);

    // R4 R5 either-edge mode with direction bits set
    wr(A_MODE, 8'h3F);
    wr(A_DIR, 8'h3F);
    chk(A_DIR, 8'h3F, "R5 dir readback");
    set_pins(6'b110000);
    chk(A_WSTS, 8'h30, "R4 R5 ee rise wsts");
    chk(A_MSTS, 8'h30, "R4 ee rise msts");
    chk(A_MISC, 8'h30, "R4 ee rise misc");
    chk(A_DATA, 8'h33, "R6 data ee");
    clr_all();
    set_pins(6'b000000);
    chk(A_WSTS, 8'h30, "R4 ee fall wsts");
    chk(A_MISC, 8'h30, "R4 ee fall misc");
    clr_all();
    set_pins(6'b000001);
    chk(A_WSTS, 8'h01, "R4 polarity ignored");
    chk(A_MISC, 8'h01, "R4 polarity ignored misc");
    chk(A_IRQ,  8'h00, "R10 no irq without enable");
    clr_all();

    // R10 R11 enables and level behaviour
    wr(A_WKEN, 8'h04);
    set_pins(6'b000101);
    chk(A_WSTS, 8'h04, "R10 wsts");
    chk(A_MSTS, 8'h04, "R10 msts without enable");
    chk(A_IRQ,  8'h02, "R11 wake only");
    wr(A_MGEN, 8'h04);
    chk(A_IRQ,  8'h03, "R11 both");
    wr(A_WSTS, 8'h04);
    chk(A_IRQ,  8'h01, "R11 level held");
    wr(A_MSTS, 8'h3F);
    chk(A_IRQ,  8'h00, "R11 released");
    wr(A_MISC, 8'h3F);

    // R1 latency on pin 3
    pins = 6'b001101;
    @(negedge clk);
    chk(A_DATA, 8'h06, "R1 data after one clock");
    chk(A_WSTS, 8'h00, "R1 status after two clocks");
    chk(A_WSTS, 8'h08, "R1 status after three clocks");
    chk(A_DATA, 8'h0E, "R1 data updated");

    // R8 edge and clear on the same clock
    pins = 6'b000101;
    @(negedge clk);
    @(negedge clk);
    wr(A_WSTS, 8'h08);
    chk(A_WSTS, 8'h08, "R8 set wins");
    wr(A_WSTS, 8'h08);
    chk(A_WSTS, 8'h00, "R7 cleared");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule